// File: doc/BRIEF.md
# Programmable CRT Timing Generator

This block produces the raster timing for a character-based or graphics display. Horizontal timing is counted in character clocks and vertical timing in scan lines. The geometry comes from a set of programmable fields, and several of those fields are stored with a fixed offset from the real count. From these fields the block derives the following outputs:

- display enable;
- horizontal and vertical blanking;
- horizontal and vertical sync;
- a pair of retrace status bits;
- a one-clock pulse that tells the address generator to restart at address zero, which gives a split screen.

The block steps only on clock cycles where the character clock enable is high. The start of each blanking or retrace window is a full-width compare against the counter. The end of each window is a short compare against only the low bits of the counter. Because of this, a window can run across the end of a line or frame and still close. Scan doubling shows every scan line twice by advancing the line counter on every second horizontal wrap. The register file, memory address generation and pixel serialisation sit outside the block.

Top module: `crt_timing_gen`

## Requirements
- R1: The character counter starts at 0 after reset. It advances by one on each cycle with `char_ce` high, and after the value `h_total + 4` it returns to 0, so one line is `h_total + 5` enabled clocks. With `char_ce` low, no counter and no registered output changes.
- R2: `disp_en` is high exactly when the character counter is at most `h_disp_end` and the line counter is below `v_disp_end`.
- R3: `h_blank` goes high on the enabled step at which the character counter becomes `h_blank_start`. It goes low on the step at which the low 6 bits of the counter equal `h_blank_end`. When both match on the same step, the start wins.
- R4: `h_sync` goes high when the character counter becomes `h_sync_start`. It goes low when the low 5 bits of the counter equal `h_sync_end`. The start wins a tie.
- R5: The line counter advances when the character counter wraps. After the value `v_total + 1` it returns to 0, so one frame is `v_total + 2` lines.
- R6: `v_blank` and `v_sync` change only when the line counter advances. `v_blank` starts at `v_blank_start` and ends when the low 7 bits of the line counter equal `v_blank_end`. `v_sync` starts at `v_sync_start` and ends when the low 4 bits equal `v_sync_end`. The start wins a tie.
- R7: `split_reset` is high for exactly one clock, following the advance at which the line counter becomes `line_cmp`.
- R8: `stat_any_retrace` is the OR of `h_sync` and `v_sync`. `stat_v_retrace` equals `v_sync`.
- R9: With `scan_double` high, the line counter advances only on every second horizontal wrap, counting from reset. This doubles the frame length in clocks.
- R10: A synchronous active-low reset clears both counters, the doubling phase, every window and `split_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| char_ce | input | 1 | Character clock enable |
| h_total | input | 8 | Line length minus 5 |
| h_disp_end | input | 8 | Last displayed character |
| h_blank_start | input | 8 | Horizontal blank start count |
| h_blank_end | input | 6 | Horizontal blank end, low-bit match |
| h_sync_start | input | 8 | Horizontal retrace start count |
| h_sync_end | input | 5 | Horizontal retrace end, low-bit match |
| v_total | input | 10 | Frame length in lines minus 2 |
| v_disp_end | input | 10 | First non-displayed line |
| v_blank_start | input | 10 | Vertical blank start line |
| v_blank_end | input | 7 | Vertical blank end, low-bit match |
| v_sync_start | input | 10 | Vertical retrace start line |
| v_sync_end | input | 4 | Vertical retrace end, low-bit match |
| line_cmp | input | 10 | Split-screen line |
| scan_double | input | 1 | Show each scan line twice |
| disp_en | output | 1 | Active display area |
| h_blank | output | 1 | Horizontal blanking |
| v_blank | output | 1 | Vertical blanking |
| h_sync | output | 1 | Horizontal retrace |
| v_sync | output | 1 | Vertical retrace |
| stat_any_retrace | output | 1 | Either retrace active |
| stat_v_retrace | output | 1 | Vertical retrace active |
| split_reset | output | 1 | One-clock address restart pulse |

## Verification
All counters, windows and the split pulse are registers that update on the enabled clock edge itself. `disp_en` and the status bits are combinational from those registers. Every result is therefore due in the cycle that directly follows the edge that applied `char_ce`, with no further delay.

The bench drives `char_ce` on the falling edge and advances its own requirement-level model right after the rising edge. It compares all outputs on the next falling edge, so each expected value lines up with the first cycle in which the design can show it. Line and frame lengths are also measured as the spacing between rising edges of `h_sync` and between `split_reset` pulses.

// File: rtl/crt_timing_pkg.sv
// Package: shared default widths and fixed count offsets for the CRT timing
// generator. Assumes the offsets are fixed by the register encoding.
package crt_timing_pkg;
    localparam int CRT_H_W     = 8;  // horizontal count fields
    localparam int CRT_V_W     = 10; // vertical count fields
    localparam int CRT_HBE_W   = 6;  // horizontal blank end match width
    localparam int CRT_HSE_W   = 5;  // horizontal sync end match width
    localparam int CRT_VBE_W   = 7;  // vertical blank end match width
    localparam int CRT_VSE_W   = 4;  // vertical sync end match width
    localparam int CRT_H_EXTRA = 5;  // line length = h_total + this
    localparam int CRT_V_EXTRA = 2;  // frame length = v_total + this

    // Window state held by each span tracker.
    typedef enum logic {
        SPAN_OFF = 1'b0,
        SPAN_ON  = 1'b1
    } span_state_e;
endpackage

// File: rtl/crt_span.sv
// Module: crt_span
// Tracks one timing window (blank or retrace). On each step the window
// opens when the next counter value equals the full-width start field, and
// otherwise closes when the low EW bits of the next value equal the end
// field. Assumes CW >= SW and CW >= EW.
module crt_span
    import crt_timing_pkg::*;
#(
    parameter int CW = 9,
    parameter int SW = 8,
    parameter int EW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [CW-1:0] cnt_next,
    input  logic [SW-1:0] start_val,
    input  logic [EW-1:0] end_low,
    output logic          active
);
    span_state_e state_q;
    logic        hit_start;
    logic        hit_end;

    assign hit_start = (cnt_next == CW'(start_val));
    assign hit_end   = (cnt_next[EW-1:0] == end_low);
    assign active    = (state_q == SPAN_ON);

    // Open on start match (priority), close on low-bit end match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SPAN_OFF;
        end else if (step) begin
            if (hit_start) begin
                state_q <= SPAN_ON;
            end else if (hit_end) begin
                state_q <= SPAN_OFF;
            end
        end
    end

    AST_SPAN_STEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(active)); // R6
endmodule

// File: rtl/crt_hcount.sv
// Module: crt_hcount
// Character counter for one scan line, plus horizontal blank and retrace
// windows. Assumes the field inputs are static while a line runs; if the
// total shrinks below the current count, the counter wraps at once.
module crt_hcount
    import crt_timing_pkg::*;
#(
    parameter int H_W   = CRT_H_W,
    parameter int HBE_W = CRT_HBE_W,
    parameter int HSE_W = CRT_HSE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic [H_W-1:0]   h_total,
    input  logic [H_W-1:0]   h_disp_end,
    input  logic [H_W-1:0]   hb_start,
    input  logic [HBE_W-1:0] hb_end,
    input  logic [H_W-1:0]   hs_start,
    input  logic [HSE_W-1:0] hs_end,
    output logic             h_active,
    output logic             h_blank,
    output logic             h_sync,
    output logic             line_tick
);
    localparam int CW = H_W + 1;

    logic [CW-1:0] hc;
    logic [CW-1:0] hc_next;
    logic [CW-1:0] h_last;
    logic          wrap;

    assign h_last    = CW'(h_total) + CW'(CRT_H_EXTRA - 1);
    assign wrap      = (hc >= h_last);
    assign hc_next   = wrap ? '0 : hc + 1'b1;
    assign line_tick = ce & wrap;
    assign h_active  = (hc <= CW'(h_disp_end));

    // Advance the character counter on each enabled clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc <= '0;
        end else if (ce) begin
            hc <= hc_next;
        end
    end

    crt_span #(.CW(CW), .SW(H_W), .EW(HBE_W)) u_hblank (
        .clk(clk), .rst_n(rst_n), .step(ce), .cnt_next(hc_next),
        .start_val(hb_start), .end_low(hb_end), .active(h_blank)
    );

    crt_span #(.CW(CW), .SW(H_W), .EW(HSE_W)) u_hsync (
        .clk(clk), .rst_n(rst_n), .step(ce), .cnt_next(hc_next),
        .start_val(hs_start), .end_low(hs_end), .active(h_sync)
    );

    AST_HC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> (hc == '0) || (hc == $past(hc) + 1'b1)); // R1
    AST_HC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> hc <= $past(h_last)); // R1
    AST_HC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(hc)); // R1
endmodule

// File: rtl/crt_vcount.sv
// Module: crt_vcount
// Line counter, vertical blank and retrace windows, scan doubling and the
// split-screen pulse. Steps only on a line tick from the horizontal counter.
// Assumes the field inputs are static while a frame runs.
module crt_vcount
    import crt_timing_pkg::*;
#(
    parameter int V_W   = CRT_V_W,
    parameter int VBE_W = CRT_VBE_W,
    parameter int VSE_W = CRT_VSE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_tick,
    input  logic             scan_double,
    input  logic [V_W-1:0]   v_total,
    input  logic [V_W-1:0]   v_disp_end,
    input  logic [V_W-1:0]   vb_start,
    input  logic [VBE_W-1:0] vb_end,
    input  logic [V_W-1:0]   vs_start,
    input  logic [VSE_W-1:0] vs_end,
    input  logic [V_W-1:0]   line_cmp,
    output logic             v_active,
    output logic             v_blank,
    output logic             v_sync,
    output logic             split_pulse
);
    localparam int CW = V_W + 1;

    logic [CW-1:0] vc;
    logic [CW-1:0] vc_next;
    logic [CW-1:0] v_last;
    logic          phase;
    logic          adv;

    assign v_last   = CW'(v_total) + CW'(CRT_V_EXTRA - 1);
    assign vc_next  = (vc >= v_last) ? '0 : vc + 1'b1;
    assign adv      = line_tick & (~scan_double | phase);
    assign v_active = (vc < CW'(v_disp_end));

    // Doubling phase: toggles per line tick while doubling, else held at 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
        end else if (line_tick) begin
            phase <= scan_double & ~phase;
        end
    end

    // Advance the line counter on each qualified line tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vc <= '0;
        end else if (adv) begin
            vc <= vc_next;
        end
    end

    // One-clock split pulse when the counter arrives at the compare line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            split_pulse <= 1'b0;
        end else begin
            split_pulse <= adv & (vc_next == CW'(line_cmp));
        end
    end

    crt_span #(.CW(CW), .SW(V_W), .EW(VBE_W)) u_vblank (
        .clk(clk), .rst_n(rst_n), .step(adv), .cnt_next(vc_next),
        .start_val(vb_start), .end_low(vb_end), .active(v_blank)
    );

    crt_span #(.CW(CW), .SW(V_W), .EW(VSE_W)) u_vsync (
        .clk(clk), .rst_n(rst_n), .step(adv), .cnt_next(vc_next),
        .start_val(vs_start), .end_low(vs_end), .active(v_sync)
    );

    AST_VC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(vc)); // R5
    AST_VC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> vc <= $past(v_last)); // R5
    AST_VSYNC_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_sync) |-> $past(line_tick)); // R6
    AST_SPLIT_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        split_pulse |-> $past(line_tick)); // R7
    AST_SPLIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        split_pulse |=> !split_pulse); // R7
    AST_DOUBLE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && scan_double && !phase) |=> $stable(vc)); // R9
endmodule

// File: rtl/crt_timing_gen.sv
// Module: crt_timing_gen (top)
// Programmable raster timing: horizontal counter feeding a line counter,
// windows for blank and retrace, display enable, status and split pulse.
// Assumes the timing fields are held static between resets.
module crt_timing_gen
    import crt_timing_pkg::*;
#(
    parameter int H_W   = CRT_H_W,
    parameter int V_W   = CRT_V_W,
    parameter int HBE_W = CRT_HBE_W,
    parameter int HSE_W = CRT_HSE_W,
    parameter int VBE_W = CRT_VBE_W,
    parameter int VSE_W = CRT_VSE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_ce,
    input  logic [H_W-1:0]   h_total,
    input  logic [H_W-1:0]   h_disp_end,
    input  logic [H_W-1:0]   h_blank_start,
    input  logic [HBE_W-1:0] h_blank_end,
    input  logic [H_W-1:0]   h_sync_start,
    input  logic [HSE_W-1:0] h_sync_end,
    input  logic [V_W-1:0]   v_total,
    input  logic [V_W-1:0]   v_disp_end,
    input  logic [V_W-1:0]   v_blank_start,
    input  logic [VBE_W-1:0] v_blank_end,
    input  logic [V_W-1:0]   v_sync_start,
    input  logic [VSE_W-1:0] v_sync_end,
    input  logic [V_W-1:0]   line_cmp,
    input  logic             scan_double,
    output logic             disp_en,
    output logic             h_blank,
    output logic             v_blank,
    output logic             h_sync,
    output logic             v_sync,
    output logic             stat_any_retrace,
    output logic             stat_v_retrace,
    output logic             split_reset
);
    logic h_active;
    logic v_active;
    logic line_tick;

    crt_hcount #(.H_W(H_W), .HBE_W(HBE_W), .HSE_W(HSE_W)) u_h (
        .clk(clk), .rst_n(rst_n), .ce(char_ce),
        .h_total(h_total), .h_disp_end(h_disp_end),
        .hb_start(h_blank_start), .hb_end(h_blank_end),
        .hs_start(h_sync_start), .hs_end(h_sync_end),
        .h_active(h_active), .h_blank(h_blank), .h_sync(h_sync),
        .line_tick(line_tick)
    );

    crt_vcount #(.V_W(V_W), .VBE_W(VBE_W), .VSE_W(VSE_W)) u_v (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
        .scan_double(scan_double),
        .v_total(v_total), .v_disp_end(v_disp_end),
        .vb_start(v_blank_start), .vb_end(v_blank_end),
        .vs_start(v_sync_start), .vs_end(v_sync_end),
        .line_cmp(line_cmp),
        .v_active(v_active), .v_blank(v_blank), .v_sync(v_sync),
        .split_pulse(split_reset)
    );

    // Combine per-axis results into the visible area and status pair.
    assign disp_en          = h_active & v_active;
    assign stat_any_retrace = h_sync | v_sync;
    assign stat_v_retrace   = v_sync;

    AST_STATUS_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        stat_v_retrace |-> stat_any_retrace); // R8
endmodule

// File: tb/crt_timing_gen_tb_top.sv
`timescale 1ns/1ps
module crt_timing_gen_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       char_ce = 1'b0;
    logic [7:0] h_total, h_disp_end, h_blank_start, h_sync_start;
    logic [5:0] h_blank_end;
    logic [4:0] h_sync_end;
    logic [9:0] v_total, v_disp_end, v_blank_start, v_sync_start, line_cmp;
    logic [6:0] v_blank_end;
    logic [3:0] v_sync_end;
    logic       scan_double;
    logic disp_en, h_blank, v_blank, h_sync, v_sync;
    logic stat_any_retrace, stat_v_retrace, split_reset;

    crt_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .char_ce(char_ce),
        .h_total(h_total), .h_disp_end(h_disp_end),
        .h_blank_start(h_blank_start), .h_blank_end(h_blank_end),
        .h_sync_start(h_sync_start), .h_sync_end(h_sync_end),
        .v_total(v_total), .v_disp_end(v_disp_end),
        .v_blank_start(v_blank_start), .v_blank_end(v_blank_end),
        .v_sync_start(v_sync_start), .v_sync_end(v_sync_end),
        .line_cmp(line_cmp), .scan_double(scan_double),
        .disp_en(disp_en), .h_blank(h_blank), .v_blank(v_blank),
        .h_sync(h_sync), .v_sync(v_sync),
        .stat_any_retrace(stat_any_retrace), .stat_v_retrace(stat_v_retrace),
        .split_reset(split_reset)
    );

    int n_chk = 0;
    int n_err = 0;

    // Reference state derived from the requirements.
    int m_hc, m_vc;
    bit m_ph, m_hb, m_hs, m_vb, m_vs, m_sp;
    int hs_per, sp_per;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input string req, input bit ok, input int act,
                         input int exp, input string what);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_hc = 0; m_vc = 0;
        m_ph = 0; m_hb = 0; m_hs = 0; m_vb = 0; m_vs = 0; m_sp = 0;
    endtask

    // One enabled or idle clock of the reference model (R1, R3-R7, R9).
    task automatic model_step(input bit ce);
        int hn, vn;
        bit wrap, adv;
        m_sp = 0;
        if (!ce) return;
        wrap = (m_hc >= int'(h_total) + 4);
        hn = wrap ? 0 : m_hc + 1;
        if (hn == int'(h_blank_start)) m_hb = 1;
        else if ((hn & 63) == int'(h_blank_end)) m_hb = 0;
        if (hn == int'(h_sync_start)) m_hs = 1;
        else if ((hn & 31) == int'(h_sync_end)) m_hs = 0;
        if (wrap) begin
            adv = !scan_double || m_ph;
            m_ph = scan_double ? !m_ph : 1'b0;
            if (adv) begin
                vn = (m_vc >= int'(v_total) + 1) ? 0 : m_vc + 1;
                if (vn == int'(v_blank_start)) m_vb = 1;
                else if ((vn & 127) == int'(v_blank_end)) m_vb = 0;
                if (vn == int'(v_sync_start)) m_vs = 1;
                else if ((vn & 15) == int'(v_sync_end)) m_vs = 0;
                if (vn == int'(line_cmp)) m_sp = 1;
                m_vc = vn;
            end
        end
        m_hc = hn;
    endtask

    task automatic cfg_a();
        h_total = 8'd5;  h_disp_end = 8'd5; h_blank_start = 8'd7;
        h_blank_end = 6'd9; h_sync_start = 8'd8; h_sync_end = 5'd9;
        v_total = 10'd8; v_disp_end = 10'd6; v_blank_start = 10'd7;
        v_blank_end = 7'd9; v_sync_start = 10'd8; v_sync_end = 4'd9;
        line_cmp = 10'd3; scan_double = 1'b0;
    endtask

    task automatic cfg_b();
        h_total = 8'd70; h_disp_end = 8'd63; h_blank_start = 8'd66;
        h_blank_end = 6'd3; h_sync_start = 8'd40; h_sync_end = 5'd10;
        v_total = 10'd20; v_disp_end = 10'd16; v_blank_start = 10'd17;
        v_blank_end = 7'd2; v_sync_start = 10'd18; v_sync_end = 4'd4;
        line_cmp = 10'd0; scan_double = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        char_ce = 1'b0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Run n cycles comparing every output to the model at each falling edge.
    task automatic run(input int n, input bit rnd, input string tag);
        string req[8] = '{"R2", "R3", "R4", "R6", "R6", "R7", "R8", "R8"};
        string nm[8]  = '{"disp_en", "h_blank", "h_sync", "v_blank",
                          "v_sync", "split_reset", "stat_any", "stat_v"};
        int  bad[8];
        int  fa[8];
        int  fe[8];
        int  last_hs = -1;
        int  last_sp = -1;
        bit  prev_hs = 0;
        bit  act[8];
        bit  exp[8];
        bit  ce;
        hs_per = -1;
        sp_per = -1;
        for (int i = 0; i < 8; i++) begin bad[i] = 0; fa[i] = 0; fe[i] = 0; end
        for (int c = 0; c < n; c++) begin
            act = '{disp_en, h_blank, h_sync, v_blank, v_sync, split_reset,
                    stat_any_retrace, stat_v_retrace};
            exp = '{(m_hc <= int'(h_disp_end)) && (m_vc < int'(v_disp_end)),
                    m_hb, m_hs, m_vb, m_vs, m_sp, m_hs | m_vs, m_vs};
            for (int i = 0; i < 8; i++) begin
                if (act[i] != exp[i]) begin
                    if (bad[i] == 0) begin fa[i] = act[i]; fe[i] = exp[i]; end
                    bad[i]++;
                end
            end
            if (h_sync && !prev_hs) begin
                if (last_hs >= 0) hs_per = c - last_hs;
                last_hs = c;
            end
            prev_hs = h_sync;
            if (split_reset) begin
                if (last_sp >= 0) sp_per = c - last_sp;
                last_sp = c;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ce = rnd ? (lfsr[0] | lfsr[5]) : 1'b1;
            char_ce = ce;
            @(posedge clk);
            model_step(ce);
            @(negedge clk);
        end
        char_ce = 1'b0;
        for (int i = 0; i < 8; i++)
            check(req[i], bad[i] == 0, fa[i], fe[i], {tag, " ", nm[i]});
    endtask

    // R10: state right after reset with configuration A.
    task automatic test_reset();
        cfg_a();
        do_reset();
        check("R10", disp_en == 1'b1, disp_en, 1, "reset disp_en");
        check("R10", {h_blank, h_sync, v_blank, v_sync, split_reset,
                      stat_any_retrace, stat_v_retrace} == 7'd0,
              {h_blank, h_sync, v_blank, v_sync, split_reset,
               stat_any_retrace, stat_v_retrace}, 0, "reset outputs");
    endtask

    // R1, R5: short geometry, continuous enable.
    task automatic test_basic();
        cfg_a();
        do_reset();
        run(300, 1'b0, "basic");
        check("R1", hs_per == 10, hs_per, 10, "basic line length");
        check("R5", sp_per == 100, sp_per, 100, "basic frame length");
    endtask

    // R3, R4, R6: end matches on low bits only, windows across wraps.
    task automatic test_lowbits();
        cfg_b();
        do_reset();
        run(3500, 1'b0, "lowbits");
        check("R1", hs_per == 75, hs_per, 75, "lowbits line length");
        check("R5", sp_per == 1650, sp_per, 1650, "lowbits frame length");
    endtask

    // R1, R3: gated enable, start wins over a simultaneous end match.
    task automatic test_gated();
        cfg_a();
        h_blank_start = 8'd4;
        h_blank_end = 6'd4;
        do_reset();
        run(600, 1'b1, "gated");
        check("R3", h_blank == 1'b1, h_blank, 1, "start priority keeps blank");
    endtask

    // R9: scan doubling doubles the frame.
    task automatic test_double();
        cfg_a();
        scan_double = 1'b1;
        do_reset();
        run(450, 1'b0, "double");
        check("R9", sp_per == 200, sp_per, 200, "doubled frame length");
        check("R1", hs_per == 10, hs_per, 10, "doubled line length");
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        cfg_a();
        test_reset();
        test_basic();
        test_lowbits();
        test_gated();
        test_double();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule